// File: doc/BRIEF.md
# Serial Channel Control Register with Handshake

This block is the per-channel control and status register of a serial port, together with the small amount of sequencing logic that the register bits steer. A host writes one byte-wide control register through a simple write strobe and reads it back combinationally. Two bits of that register choose the prescaler exponent fed to an external baud-rate divider, and an extra divide-select input picks between the two rates of each pair. A mode bit decides whether the shared handshake pin is a clear-to-send input or a request-to-send output. Another bit asks for most-significant-bit-first ordering, and that request is honoured only in clocked synchronous mode.

On the transmit side the block holds a one-byte transmit buffer. It moves the byte into the transmit shift register only when the shift register is empty and, in clear-to-send mode, the synchronized handshake input is low. A read-only flag reports whether the shift register is empty. On the receive side the request-to-send output follows the receiver's frame start and frame done strobes. It is forced high whenever reception is disabled.

Top module: `uart_hs_ctrl`

## Requirements
- R1: After reset the register reads 8'h08, `rts_pin` is 1 and `tx_load` is 0.
- R2: `presc_log2` is the base-2 exponent of the count-source divider. Bits 1:0 equal to 00, 01, 10 and 11 give 1, 4, 6 and 9 when `div_sel` is 0. With `div_sel` at 1 they give 2, 5, 7 and 10.
- R3: Bit 2 reads back as written and drives `hs_oe`. A 1 makes the handshake pin a request-to-send output.
- R4: Whenever `rx_en` is 0, `rts_pin` is 1 after the next clock edge.
- R5: With `rx_en` at 1, `rts_pin` goes to 0 one edge after reception is enabled. It goes to 1 one edge after an `rx_start` strobe, stays at 1 until `rx_done`, and goes to 0 one edge after the `rx_done` strobe.
- R6: When `rx_start` and `rx_done` are high in the same cycle, `rts_pin` goes to 0.
- R7: A byte written with `tbuf_wr` is moved once the shift register is empty and the handshake gate is open. That cycle gives a one-cycle `tx_load` pulse, `tx_data` holds the byte, and bit 3 reads 0. A byte written while the shift register is busy is moved in the cycle after the register empties.
- R8: In clear-to-send mode (bit 2 = 0), `cts_n` passes through two flops. A move happens only while the synchronized value is 0, so `tx_load` rises on the third edge after `cts_n` falls. In request-to-send mode `cts_n` has no effect.
- R9: A `tx_done` strobe while the shift register is busy sets bit 3 to 1 at the next edge.
- R10: Bit 7 reads back as written. When bit 7 is 1 and `sync_mode` is 1, `tx_data` is the buffered byte bit-reversed, so `tx_data[0]` is sent first. Otherwise `tx_data` equals the buffered byte.
- R11: Writes to bits 6:4 are ignored and those bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| div_sel | input | 1 | Picks the slower rate of each prescaler pair |
| sync_mode | input | 1 | 1 = clocked synchronous mode, 0 = asynchronous |
| presc_log2 | output | 4 | Prescaler exponent for the baud divider |
| hs_oe | output | 1 | Handshake pin output enable (request-to-send mode) |
| cts_n | input | 1 | Clear-to-send input, active low, asynchronous |
| rts_pin | output | 1 | Request-to-send level, high = not ready |
| rx_en | input | 1 | Receive enable |
| rx_start | input | 1 | Receiver frame start strobe |
| rx_done | input | 1 | Receiver frame done strobe |
| tbuf_wr | input | 1 | Transmit buffer write strobe |
| tbuf_wdata | input | 8 | Transmit buffer write data |
| tx_load | output | 1 | One-cycle pulse when the shift register is loaded |
| tx_data | output | 8 | Byte handed to the shift register, send order bit 0 first |
| tx_done | input | 1 | Transmitter finished strobe |

## Verification
The prescaler selection is driven through all eight combinations of the two source bits and `div_sel`. A swapped pair or a wrong exponent therefore shows up as a distinct value. The transmit move is tried with the handshake input held high and then released, in the other mode with the input ignored, and with a byte that waits behind a busy shift register. Together these separate the gating on the input, the gating on the empty flag and the synchronizer latency. The request-to-send level is driven through enable, a start-then-done frame, a disable in mid-frame and simultaneous strobes. Bit ordering uses an asymmetric byte under both values of `sync_mode`, so a reversal that ignores the mode is caught.

// File: rtl/uart_hs_ctrl.sv
module uart_hs_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          div_sel,
  input  logic          sync_mode,
  output logic [3:0]    presc_log2,
  output logic          hs_oe,
  input  logic          cts_n,
  output logic          rts_pin,
  input  logic          rx_en,
  input  logic          rx_start,
  input  logic          rx_done,
  input  logic          tbuf_wr,
  input  logic [DW-1:0] tbuf_wdata,
  output logic          tx_load,
  output logic [DW-1:0] tx_data,
  input  logic          tx_done
);

  logic [1:0]    src_q;
  logic          rts_mode_q;
  logic          msb_q;
  logic          empty_q;
  logic          cts_s1, cts_s2;
  logic          frame_q, frame_nx;
  logic          buf_full_q;
  logic [DW-1:0] buf_q;
  logic          xfer;
  wire           unused_bits = ^reg_wdata[6:4];

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] d);
    for (int i = 0; i < DW; i++) flip[i] = d[DW-1-i];
  endfunction

  assign reg_rdata = {msb_q, 3'b000, empty_q, rts_mode_q, src_q};
  assign hs_oe     = rts_mode_q;

  always_comb begin
    unique case (src_q)
      2'b00: presc_log2 = div_sel ? 4'd2  : 4'd1;
      2'b01: presc_log2 = div_sel ? 4'd5  : 4'd4;
      2'b10: presc_log2 = div_sel ? 4'd7  : 4'd6;
      default: presc_log2 = div_sel ? 4'd10 : 4'd9;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_q <= 2'b00; rts_mode_q <= 1'b0; msb_q <= 1'b0;
    end else if (reg_wr) begin
      src_q <= reg_wdata[1:0]; rts_mode_q <= reg_wdata[2]; msb_q <= reg_wdata[7];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {cts_s2, cts_s1} <= 2'b11;
    else        {cts_s2, cts_s1} <= {cts_s1, cts_n};

  assign frame_nx = rx_en & ~rx_done & (rx_start | frame_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_q <= 1'b0; rts_pin <= 1'b1;
    end else begin
      frame_q <= frame_nx; rts_pin <= ~rx_en | frame_nx;
    end

  assign xfer = buf_full_q & empty_q & (rts_mode_q | ~cts_s2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      buf_full_q <= 1'b0; buf_q <= '0; empty_q <= 1'b1;
      tx_load <= 1'b0; tx_data <= '0;
    end else begin
      tx_load <= xfer;
      if (xfer) begin
        empty_q <= 1'b0;
        buf_full_q <= 1'b0;
        tx_data <= (msb_q & sync_mode) ? flip(buf_q) : buf_q;
      end else if (tx_done) empty_q <= 1'b1;
      if (tbuf_wr) begin
        buf_full_q <= 1'b1; buf_q <= tbuf_wdata;
      end
    end

  AST_RTS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> rts_pin);                                          // R4
  AST_RTS_DONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rx_done |=> !rts_pin);                               // R6
  AST_LOAD_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> !reg_rdata[3] && $past(reg_rdata[3]));            // R7
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !$past(hs_oe) |-> !$past(cts_s2));                 // R8
  AST_DONE_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !reg_rdata[3] && !tbuf_wr |=> reg_rdata[3]);       // R9

endmodule

// File: tb/uart_hs_ctrl_tb.sv
module uart_hs_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, div_sel = 0, sync_mode = 0, cts_n = 1;
  logic rx_en = 0, rx_start = 0, rx_done = 0, tbuf_wr = 0, tx_done = 0;
  logic [7:0] reg_wdata = 0, tbuf_wdata = 0;
  logic [7:0] reg_rdata, tx_data;
  logic [3:0] presc_log2;
  logic hs_oe, rts_pin, tx_load;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_hs_ctrl u_dut (.clk, .rst_n, .reg_wr, .reg_wdata, .reg_rdata, .div_sel,
    .sync_mode, .presc_log2, .hs_oe, .cts_n, .rts_pin, .rx_en, .rx_start,
    .rx_done, .tbuf_wr, .tbuf_wdata, .tx_load, .tx_data, .tx_done);

  // {src[1:0], div_sel, expected exponent[3:0]}
  localparam logic [6:0] VEC [8] = '{
    {2'b00, 1'b0, 4'd1}, {2'b00, 1'b1, 4'd2}, {2'b01, 1'b0, 4'd4}, {2'b01, 1'b1, 4'd5},
    {2'b10, 1'b0, 4'd6}, {2'b10, 1'b1, 4'd7}, {2'b11, 1'b0, 4'd9}, {2'b11, 1'b1, 4'd10}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    reg_wdata = v; reg_wr = 1; step(); reg_wr = 0;
  endtask

  task automatic push(logic [7:0] v);
    tbuf_wdata = v; tbuf_wr = 1; step(); tbuf_wr = 0;
  endtask

  task automatic done_pulse();
    tx_done = 1; step(); tx_done = 0;
  endtask

  initial begin
    step(3); rst_n = 1; step();
    chk("R1 reg", reg_rdata, 8'h08);
    chk("R1 rts", {7'd0, rts_pin}, 8'd1);
    chk("R1 load", {7'd0, tx_load}, 8'd0);

    for (int i = 0; i < 8; i++) begin
      div_sel = VEC[i][4];
      wr_ctrl({6'd0, VEC[i][6:5]});
      chk("R2 presc", {4'd0, presc_log2}, {4'd0, VEC[i][3:0]});
    end
    div_sel = 0;

    wr_ctrl(8'h73);
    chk("R11 reserved", reg_rdata, 8'h0B);
    wr_ctrl(8'h04);
    chk("R3 readback", reg_rdata, 8'h0C);
    chk("R3 oe", {7'd0, hs_oe}, 8'd1);
    wr_ctrl(8'h00);
    chk("R3 oe off", {7'd0, hs_oe}, 8'd0);

    chk("R4 disabled", {7'd0, rts_pin}, 8'd1);
    rx_en = 1; step();
    chk("R5 enable low", {7'd0, rts_pin}, 8'd0);
    rx_start = 1; step(); rx_start = 0;
    chk("R5 start high", {7'd0, rts_pin}, 8'd1);
    step(2);
    chk("R5 hold high", {7'd0, rts_pin}, 8'd1);
    rx_done = 1; step(); rx_done = 0;
    chk("R5 done low", {7'd0, rts_pin}, 8'd0);
    rx_start = 1; step(); rx_start = 0;
    rx_en = 0; step();
    chk("R4 disable mid-frame", {7'd0, rts_pin}, 8'd1);
    rx_en = 1; step();
    rx_start = 1; rx_done = 1; step(); rx_start = 0; rx_done = 0;
    chk("R6 both strobes", {7'd0, rts_pin}, 8'd0);

    push(8'hA5);
    step(3);
    chk("R8 held by cts", {7'd0, tx_load}, 8'd0);
    chk("R8 still empty", {7'd0, reg_rdata[3]}, 8'd1);
    cts_n = 0; step(2);
    chk("R8 sync latency", {7'd0, tx_load}, 8'd0);
    step();
    chk("R7 load pulse", {7'd0, tx_load}, 8'd1);
    chk("R7 data", tx_data, 8'hA5);
    chk("R7 busy flag", {7'd0, reg_rdata[3]}, 8'd0);
    step();
    chk("R7 pulse one cycle", {7'd0, tx_load}, 8'd0);
    done_pulse();
    chk("R9 empty again", {7'd0, reg_rdata[3]}, 8'd1);

    cts_n = 1; step(3);
    wr_ctrl(8'h04);
    push(8'h3C); step();
    chk("R8 rts mode ignores cts", {7'd0, tx_load}, 8'd1);
    chk("R7 data rts mode", tx_data, 8'h3C);
    push(8'h5A); step(2);
    chk("R7 waits while busy", {7'd0, tx_load}, 8'd0);
    done_pulse();
    chk("R9 empty", {7'd0, reg_rdata[3]}, 8'd1);
    step();
    chk("R7 queued load", {7'd0, tx_load}, 8'd1);
    chk("R7 queued data", tx_data, 8'h5A);
    done_pulse();

    wr_ctrl(8'h84); sync_mode = 1;
    chk("R10 readback", reg_rdata, 8'h8C);
    push(8'h03); step();
    chk("R10 msb first", tx_data, 8'hC0);
    done_pulse();
    sync_mode = 0;
    push(8'h03); step();
    chk("R10 async forces lsb", tx_data, 8'h03);
    done_pulse();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule